// File: doc/BRIEF.md
# Bit-Masked GPIO Port Controller

This block controls one 8-pin general-purpose I/O port through a simple single-cycle register bus. Software reaches the pin data through a window of 256 word addresses. The word index inside that window is a per-pin mask, so one bus write changes exactly the chosen output latches and leaves every other pin alone. No read-modify-write sequence is needed, so code on another thread cannot corrupt the port between a read and a write. A read through the same window returns only the masked pins.

Next to the data window sit the direction, digital-enable, alternate-select, pull-up and pull-down registers. A key-based lock and a per-pin commit register guard a parameterised set of protected pins. While the port is locked, configuration writes to those pins are dropped. Reading the lock register locks the port again. Pin inputs pass through a two-flop synchronizer before they can be read.

Top module: `gpio_mask_port`

## Requirements
- R1: A write with bus_addr[11:10]==0 targets the data window. bus_addr[9:2] is the pin mask. Output latch bit i takes bus_wdata[i] when mask bit i is 1 and otherwise keeps its value.
- R2: A data-window read returns pin value i in bus_rdata[i] when mask bit i is 1. Unmasked bits read 0, and bus_rdata[31:8] reads 0.
- R3: The pin value of a pin is its output latch when its direction bit is 1. When its direction bit is 0, it is the two-flop-synchronized pin_in. A read issued in the same cycle that pin_in changes still returns the old level.
- R4: Masked writes update the output latches of input pins as well. The stored level appears on pin_out and in reads once the pin is turned to output.
- R5: After reset the direction, enable, alternate, pull and commit registers and the output latches are 0, and the port is locked.
- R6: pin_out equals the output latches. pin_oe bit i is 1 only when both direction bit i and digital-enable bit i are 1.
- R7: A write of 32'h4C0C_6B1D to the lock register (byte offset 0x414) unlocks the port, and any other value locks it. A lock read returns 1 when locked and 0 when unlocked.
- R8: Every read of the lock register leaves the port locked afterwards.
- R9: The commit register (offset 0x418) is written only while the port is unlocked. Otherwise the write is dropped.
- R10: For pins in PROT_PINS (default bits 0 and 7), writes to digital-enable (0x404), alternate-select (0x408), pull-up (0x40C) and pull-down (0x410) change the bit only when the port is unlocked and commit bit i is 1. Other pins are always writable. Direction (0x400) is never guarded.
- R11: Setting a pull-up bit clears the same pull-down bit, and the reverse also holds. Both are never set together.
- R12: bus_ready is 1 exactly one cycle after each cycle with bus_sel, and bus_rdata is valid in that cycle. Unmapped offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the port space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is 1 |
| bus_ready | output | 1 | Access response |
| pin_out | output | 8 | Output levels to pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_in | input | 8 | Raw pad input levels |

## Verification
A masked data write and an edge on an input pin can meet in the same cycle. The read mux then merges freshly written latch bits with a pin_in level that is still in the synchronizer. The bench changes pin_in on the very cycle of a write to the output half of the port. It reads back at once and again after the synchronizer has settled. It expects the output pins to show the new latch value both times, and the input pins to show the old level first and the new level afterwards.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PIN_W   = 8;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;

  typedef enum logic [2:0] {
    RS_NONE, RS_DIR, RS_DEN, RS_ALT, RS_PUP, RS_PDN, RS_LOCK, RS_COMMIT
  } reg_sel_e;

  // byte offsets of the configuration registers (outside the data window)
  localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_DEN    = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_ALT    = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_PUP    = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_PDN    = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h418;

  function automatic logic in_data_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ADDR_W-2] == 2'b00;
  endfunction

  function automatic logic [PIN_W-1:0] window_mask(input logic [ADDR_W-1:0] a);
    return a[PIN_W+1:2];
  endfunction

  function automatic reg_sel_e decode_cfg(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DIR:    return RS_DIR;
      OFS_DEN:    return RS_DEN;
      OFS_ALT:    return RS_ALT;
      OFS_PUP:    return RS_PUP;
      OFS_PDN:    return RS_PDN;
      OFS_LOCK:   return RS_LOCK;
      OFS_COMMIT: return RS_COMMIT;
      default:    return RS_NONE;
    endcase
  endfunction

  // bits selected by mask come from val, the rest from old
  function automatic logic [PIN_W-1:0] merge_bits(input logic [PIN_W-1:0] old,
                                                  input logic [PIN_W-1:0] mask,
                                                  input logic [PIN_W-1:0] val);
    return (old & ~mask) | (val & mask);
  endfunction

  // per-pin view: output latch for outputs, synchronized input otherwise
  function automatic logic [PIN_W-1:0] pin_view(input logic [PIN_W-1:0] dir,
                                                input logic [PIN_W-1:0] latch,
                                                input logic [PIN_W-1:0] sync);
    return (dir & latch) | (~dir & sync);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= raw_in[i];
        s2 <= s1;
      end
    end
    assign sync_out[i] = s2;
  end
endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch
  import gpio_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [PIN_W-1:0] data_mask,
  input  logic [PIN_W-1:0] data_val,
  output logic [PIN_W-1:0] latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (data_wr) latch_q <= merge_bits(latch_q, data_mask, data_val);
  end

  // R1: unmasked pins keep their latch value across a masked write
  p_unmasked_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((latch_q ^ $past(latch_q)) & ~$past(data_mask)) == '0);

  // R1: masked pins take the written value
  p_masked_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((latch_q ^ $past(data_val)) & $past(data_mask)) == '0);

  // R6: latches move only on data writes
  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(latch_q));
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter logic [PIN_W-1:0]  PROT_PINS = 8'h81,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C0C_6B1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  reg_sel_e          cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  den_q,
  output logic [PIN_W-1:0]  alt_q,
  output logic [PIN_W-1:0]  pup_q,
  output logic [PIN_W-1:0]  pdn_q,
  output logic [PIN_W-1:0]  commit_q,
  output logic              unlocked_q
);
  logic [PIN_W-1:0] wbits;
  logic [PIN_W-1:0] allow;
  logic             guard_wr;
  logic             lock_rd;
  logic             commit_wr;

  assign wbits     = cfg_wdata[PIN_W-1:0];
  assign allow     = ~PROT_PINS | (unlocked_q ? commit_q : '0);
  assign guard_wr  = cfg_wr && (cfg_sel inside {RS_DEN, RS_ALT, RS_PUP, RS_PDN});
  assign lock_rd   = cfg_rd && (cfg_sel == RS_LOCK);
  assign commit_wr = cfg_wr && (cfg_sel == RS_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= '0;
      den_q      <= '0;
      alt_q      <= '0;
      pup_q      <= '0;
      pdn_q      <= '0;
      commit_q   <= '0;
      unlocked_q <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_sel)
        RS_DIR: dir_q <= wbits;
        RS_DEN: den_q <= merge_bits(den_q, allow, wbits);
        RS_ALT: alt_q <= merge_bits(alt_q, allow, wbits);
        RS_PUP: begin
          pup_q <= merge_bits(pup_q, allow, wbits);
          pdn_q <= pdn_q & ~(wbits & allow);
        end
        RS_PDN: begin
          pdn_q <= merge_bits(pdn_q, allow, wbits);
          pup_q <= pup_q & ~(wbits & allow);
        end
        RS_LOCK:   unlocked_q <= (cfg_wdata == UNLOCK_KEY);
        RS_COMMIT: if (unlocked_q) commit_q <= wbits;
        default: ;
      endcase
    end else if (lock_rd) begin
      unlocked_q <= 1'b0;
    end
  end

  // R10: protected bits of guarded registers hold while locked
  p_prot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_wr && !unlocked_q) |=>
      (((den_q ^ $past(den_q)) | (alt_q ^ $past(alt_q)) |
        (pup_q ^ $past(pup_q)) | (pdn_q ^ $past(pdn_q))) & PROT_PINS) == '0);

  // R11: pull-up and pull-down never both set on a pin
  p_pull_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pup_q & pdn_q) == '0);

  // R8: a lock read always leaves the port locked
  p_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rd |=> !unlocked_q);

  // R9: commit ignores writes while locked
  p_commit_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_wr && !unlocked_q) |=> $stable(commit_q));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter logic [PIN_W-1:0]  PROT_PINS  = 8'h81,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C0C_6B1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  input  logic [PIN_W-1:0]  pin_in
);
  localparam int PAD_W = DATA_W - PIN_W;

  logic             hit_data;
  logic             data_wr;
  logic             data_rd;
  logic             cfg_wr;
  logic             cfg_rd;
  reg_sel_e         cfg_sel;
  logic [PIN_W-1:0] mask;
  logic [PIN_W-1:0] latch_q;
  logic [PIN_W-1:0] sync_in;
  logic [PIN_W-1:0] dir_q, den_q, alt_q, pup_q, pdn_q, commit_q;
  logic             unlocked_q;
  logic [PIN_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic             ready_q;

  assign hit_data = in_data_window(bus_addr);
  assign mask     = window_mask(bus_addr);
  assign cfg_sel  = hit_data ? RS_NONE : decode_cfg(bus_addr);
  assign data_wr  = bus_sel &&  bus_we && hit_data;
  assign data_rd  = bus_sel && !bus_we && hit_data;
  assign cfg_wr   = bus_sel &&  bus_we && !hit_data;
  assign cfg_rd   = bus_sel && !bus_we && !hit_data;

  gpio_in_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(sync_in)
  );

  gpio_data_latch u_latch (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_mask(mask),
    .data_val(bus_wdata[PIN_W-1:0]), .latch_q(latch_q)
  );

  gpio_cfg_bank #(.PROT_PINS(PROT_PINS), .UNLOCK_KEY(UNLOCK_KEY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_sel(cfg_sel), .cfg_wdata(bus_wdata),
    .dir_q(dir_q), .den_q(den_q), .alt_q(alt_q), .pup_q(pup_q),
    .pdn_q(pdn_q), .commit_q(commit_q), .unlocked_q(unlocked_q)
  );

  always_comb begin
    if (hit_data) rd_mux = pin_view(dir_q, latch_q, sync_in) & mask;
    else begin
      case (cfg_sel)
        RS_DIR:    rd_mux = dir_q;
        RS_DEN:    rd_mux = den_q;
        RS_ALT:    rd_mux = alt_q;
        RS_PUP:    rd_mux = pup_q;
        RS_PDN:    rd_mux = pdn_q;
        RS_LOCK:   rd_mux = {{(PIN_W-1){1'b0}}, ~unlocked_q};
        RS_COMMIT: rd_mux = commit_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= bus_sel;
      rdata_q <= (bus_sel && !bus_we) ? {{PAD_W{1'b0}}, rd_mux} : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_ready = ready_q;
  assign pin_out   = latch_q;
  assign pin_oe    = dir_q & den_q;

  // R2: masked read clears unmasked and upper bits
  p_rd_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> ((bus_rdata[PIN_W-1:0] & ~$past(mask)) == '0) &&
                (bus_rdata[DATA_W-1:PIN_W] == '0));

  // R12: one response for each request, one cycle later
  p_ready_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);
  p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);

  // R6: an enabled output pin drives only when configured as output
  p_oe_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == '0);
endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [7:0]  pin_out, pin_oe;
  logic [7:0]  pin_in = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [11:0] A_DIR = 12'h400, A_DEN = 12'h404, A_ALT = 12'h408,
                          A_PUP = 12'h40C, A_PDN = 12'h410, A_LOCK = 12'h414,
                          A_COMMIT = 12'h418;
  localparam logic [31:0] KEY = 32'h4C0C_6B1D;

  always #10 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] dwin(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk("R12 ready", {31'b0, bus_ready}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R5 pin_out", {24'b0, pin_out}, 0);
    chk("R5 pin_oe", {24'b0, pin_oe}, 0);
    bus_read(A_DIR, d);    chk("R5 dir", d, 0);
    bus_read(A_COMMIT, d); chk("R5 commit", d, 0);
    bus_read(A_LOCK, d);   chk("R5 locked", d, 1);
  endtask

  task automatic t_masked_write;
    bus_write(dwin(8'h26), 32'hEB);
    chk("R1 mask 26", {24'b0, pin_out}, 32'h22);
    bus_write(dwin(8'hFF), 32'h0);
    chk("R1 mask ff", {24'b0, pin_out}, 0);
    bus_write(dwin(8'h0F), 32'hFF);
    bus_write(dwin(8'hF0), 32'hA5);
    chk("R1 two halves", {24'b0, pin_out}, 32'hAF);
    bus_write(dwin(8'h00), 32'hFF);
    chk("R1 empty mask", {24'b0, pin_out}, 32'hAF);
  endtask

  task automatic t_masked_read;
    logic [31:0] d;
    bus_write(A_DIR, 32'hFF);
    bus_read(dwin(8'h3C), d);
    chk("R2 mask 3c", d, 32'h2C);
    bus_read(dwin(8'h00), d);
    chk("R2 mask 00", d, 0);
  endtask

  task automatic t_input_read;
    logic [31:0] d;
    bus_write(A_DIR, 32'h0F);
    pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    bus_read(dwin(8'hFF), d);
    chk("R3 mixed dir", d, 32'h5F);
    // change and read in the same cycle: old level
    @(negedge clk);
    pin_in = 8'hA5;
    bus_sel = 1; bus_we = 0; bus_addr = dwin(8'hF0);
    @(negedge clk);
    bus_sel = 0;
    chk("R3 sync delay", bus_rdata, 32'h50);
    repeat (3) @(negedge clk);
    bus_read(dwin(8'hF0), d);
    chk("R3 settled", d, 32'hA0);
  endtask

  task automatic t_input_write;
    logic [31:0] d;
    bus_write(dwin(8'hF0), 32'h30);
    chk("R4 input latch on pin_out", {24'b0, pin_out}, 32'h3F);
    bus_read(dwin(8'hF0), d);
    chk("R4 input pins read pad", d, 32'hA0);
    bus_write(A_DIR, 32'hFF);
    bus_read(dwin(8'hF0), d);
    chk("R4 latch after turning output", d, 32'h30);
    bus_write(A_DIR, 32'h0F);
    bus_write(A_DEN, 32'hFF);
    bus_read(A_DEN, d);
    chk("R10 den locked", d, 32'h7E);
    chk("R6 pin_oe", {24'b0, pin_oe}, 32'h0E);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    bus_write(A_ALT, 32'hFF);
    bus_read(A_ALT, d);    chk("R10 alt locked", d, 32'h7E);
    bus_write(A_LOCK, 32'h1234_5678);
    bus_read(A_LOCK, d);   chk("R7 bad key", d, 1);
    bus_write(A_COMMIT, 32'hFF);
    bus_read(A_COMMIT, d); chk("R9 commit locked", d, 0);
    bus_write(A_LOCK, KEY);
    bus_write(A_DEN, 32'hFF);
    bus_read(A_DEN, d);    chk("R10 unlocked no commit", d, 32'h7E);
    bus_write(A_COMMIT, 32'h81);
    bus_read(A_COMMIT, d); chk("R9 commit unlocked", d, 32'h81);
    bus_write(A_DEN, 32'hFF);
    bus_read(A_DEN, d);    chk("R10 committed", d, 32'hFF);
    bus_read(A_LOCK, d);   chk("R7 unlocked reads 0", d, 0);
    bus_read(A_LOCK, d);   chk("R8 relocked", d, 1);
    bus_write(A_DEN, 32'h00);
    bus_read(A_DEN, d);    chk("R10 relock guards", d, 32'h81);
    bus_write(A_DIR, 32'h00);
    bus_read(A_DIR, d);    chk("R10 dir unguarded", d, 0);
  endtask

  task automatic t_pull;
    logic [31:0] d;
    bus_write(A_PUP, 32'h3C);
    bus_write(A_PDN, 32'h0C);
    bus_read(A_PDN, d); chk("R11 pdn", d, 32'h0C);
    bus_read(A_PUP, d); chk("R11 pup cleared", d, 32'h30);
    bus_write(A_PUP, 32'h04);
    bus_read(A_PDN, d); chk("R11 pdn cleared", d, 32'h08);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(A_DIR, 32'h0F);
    bus_write(12'h800, 32'hFF);
    bus_read(12'h800, d); chk("R12 unmapped read", d, 0);
    bus_read(A_DIR, d);   chk("R12 unmapped write ignored", d, 32'h0F);
  endtask

  task automatic t_concurrent;
    logic [31:0] d;
    // dir = 0x0F; write low pins while high input pins change
    @(negedge clk);
    pin_in = 8'h3C;
    bus_sel = 1; bus_we = 1; bus_addr = dwin(8'h0F); bus_wdata = 32'h09;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    bus_sel = 1; bus_addr = dwin(8'hFF);
    @(negedge clk);
    bus_sel = 0;
    chk("R3 concurrent early", bus_rdata, 32'hA9);
    repeat (3) @(negedge clk);
    bus_read(dwin(8'hFF), d);
    chk("R1 concurrent settled", d, 32'h39);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_masked_write();
    t_masked_read();
    t_input_read();
    t_input_write();
    t_lock();
    t_pull();
    t_unmapped();
    t_concurrent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule